// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs single register accesses to an Ethernet PHY over the two-wire management interface, MDC (clock) and MDIO (bidirectional data). A host presents a 5-bit PHY address, a 5-bit register address, a read/write select and 16 bits of write data, then pulses a start strobe. The block derives MDC from the system clock with a programmable half-period divider. It drives MDIO through a data/output-enable pair that feeds a tri-state pad. When the frame completes it returns a one-cycle done pulse, an error flag and, for reads, the 16-bit register value.

Every access opens with a full run of ones on MDIO. This lets a PHY that lost frame alignment recover on any access. During a read the block releases the line for both turnaround slots and requires the PHY to pull the second one low. If the line stays high, no PHY answered. The block then abandons the frame, clocks 32 idle MDC cycles with the line released so that the PHY can resynchronise, and reports an error with zero data.

Incoming MDIO passes through a two-flop synchroniser. Each bit is captured at the point where the synchronised view shows the level the line had at the MDC rising edge.

Top module: `mdio_master`

## Requirements
- R1: Every access begins with 32 MDC cycles during which MDIO is driven (output-enable high) at logic 1, for reads and writes alike.
- R2: After the ones, the block drives the start pair 0,1 and then the opcode: 1,0 for a read (`rd_i`=1) and 0,1 for a write (`rd_i`=0).
- R3: The PHY address follows the opcode, bit 4 first. The register address comes next, also bit 4 first.
- R4: MDIO and its output-enable change only while MDC is low. MDC stays high for exactly CLK_DIV system clocks in each cycle, and the PHY samples on the MDC rising edge.
- R5: For a write, the turnaround is driven 1,0 and the 16 data bits follow, bit 15 first. The line is then released for one final MDC cycle, so the frame has 65 MDC cycles.
- R6: For a read, the output-enable is low from the first turnaround slot (MDC cycle 46 of the frame) to the end of the frame. The line level at the rising edge of the second turnaround slot must be 0.
- R7: For a good read, 16 data bits are taken from the line levels at the rising edges of MDC cycles 48..63, bit 15 first. One released idle cycle ends the frame (65 cycles), `rdata_o` presents the word and `err_o` is 0.
- R8: If the second turnaround slot reads 1, the frame stops after that slot and 32 more MDC cycles follow with MDIO released (80 cycles in all). The access then ends with `err_o`=1 and `rdata_o`=0.
- R9: `busy_o` rises only in response to a start strobe and stays high until the access ends. `done_o` is a single-cycle pulse that coincides with `busy_o` falling. A start strobe while busy has no effect.
- R10: In reset and while idle, MDC is low and the output-enable is low. After reset, `busy_o`, `done_o`, `err_o` and `rdata_o` are all zero.
- R11: `err_o` and `rdata_o` change only together with `done_o` and hold their values until the next access ends. A write ends with `err_o`=0 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to begin an access |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address within the PHY |
| wdata_i | input | 16 | Data for a write |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle pulse when an access ends |
| err_o | output | 1 | Last access ended with no PHY response |
| rdata_o | output | 16 | Data from the last good read |
| mdc_o | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO level to drive when enabled |
| mdio_oe_o | output | 1 | Output-enable for the MDIO pad |
| mdio_i | input | 1 | MDIO level seen at the pad |

## Verification
The bound checker watches several properties on every cycle: MDIO and its enable move only while MDC is low, each MDC high phase lasts CLK_DIV clocks, and the idle pad stays quiet. It also checks that busy rises only after a start strobe, that done falls together with busy, and that the result flags move only with done. Other behaviour shows only in the bench's scenarios, where a PHY model records the line at each MDC rise and answers reads. These scenarios cover the bit order of the frame and the opcode and turnaround encodings, the 65- versus 80-cycle frame lengths, the captured read word, and the abort with its error and zeroed data. A start strobe injected in mid-frame must leave the frame unchanged.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_AW    = 5;
  localparam int REG_AW    = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_BITS  = 4 + PHY_AW + REG_AW;
  localparam int TA_BITS   = 2;
  localparam int XFER_BITS = HDR_BITS + TA_BITS + DATA_W;
  localparam int TA_CHK    = HDR_BITS + 1;
  localparam int DATA_IDX  = HDR_BITS + TA_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_XFER,
    ST_TAIL,
    ST_RECOV
  } mdio_state_e;

endpackage

// File: rtl/mdio_sync_ff.sv
module mdio_sync_ff #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF     = 40,
  parameter int SAMPLE_AT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic mdc_o,
  output logic bit_start_o,
  output logic sample_o,
  output logic bit_end_o
);

  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] SAMP = CW'(SAMPLE_AT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!en_i) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      ph_d  = ~ph_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign mdc_o       = ph_q;
  assign bit_start_o = en_i && !ph_q && (cnt_q == '0);
  assign sample_o    = en_i &&  ph_q && (cnt_q == SAMP);
  assign bit_end_o   = en_i &&  ph_q && (cnt_q == LAST);

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int PRE_LEN   = 32,
  parameter int RECOV_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_start_i,
  input  logic              sample_i,
  input  logic              bit_end_i,
  input  logic              mdio_s_i,
  output logic              clk_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdio_o,
  output logic              mdio_oe_o
);

  localparam int MAX_LEN = (PRE_LEN > RECOV_LEN) ?
                           ((PRE_LEN > XFER_BITS) ? PRE_LEN : XFER_BITS) :
                           ((RECOV_LEN > XFER_BITS) ? RECOV_LEN : XFER_BITS);
  localparam int CNT_W = $clog2(MAX_LEN) + 1;
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_LEN - 1);
  localparam logic [CNT_W-1:0] XFER_LAST  = CNT_W'(XFER_BITS - 1);
  localparam logic [CNT_W-1:0] REL_SLOT   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] TA_SLOT    = CNT_W'(TA_CHK);
  localparam logic [CNT_W-1:0] DATA_SLOT  = CNT_W'(DATA_IDX);

  mdio_state_e          state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [XFER_BITS-1:0] tx_q, tx_d;
  logic [DATA_W-1:0]    rx_q, rx_d;
  logic                 rd_q, rd_d;
  logic                 ta_bad_q, ta_bad_d;
  logic                 mdio_q, mdio_d;
  logic                 oe_q, oe_d;
  logic                 done_q, done_d;
  logic                 err_q, err_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic                 ta_fail;

  // turnaround verdict, usable even when sample and bit end coincide
  assign ta_fail = (sample_i && (cnt_q == TA_SLOT)) ? mdio_s_i : ta_bad_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    rd_d     = rd_q;
    ta_bad_d = ta_bad_q;
    mdio_d   = mdio_q;
    oe_d     = oe_q;
    done_d   = 1'b0;
    err_d    = err_q;
    rdata_d  = rdata_q;
    unique case (state_q)
      ST_IDLE: begin
        oe_d   = 1'b0;
        mdio_d = 1'b0;
        if (start_i) begin
          state_d  = ST_PRE;
          cnt_d    = '0;
          rd_d     = rd_i;
          rx_d     = '0;
          ta_bad_d = 1'b0;
          tx_d     = {2'b01, (rd_i ? 2'b10 : 2'b01), phy_addr_i, reg_addr_i,
                      (rd_i ? 2'b00 : 2'b10), (rd_i ? {DATA_W{1'b0}} : wdata_i)};
        end
      end
      ST_PRE: begin
        if (bit_start_i) begin
          mdio_d = 1'b1;
          oe_d   = 1'b1;
        end
        if (bit_end_i) begin
          if (cnt_q == PRE_LAST) begin
            state_d = ST_XFER;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_XFER: begin
        if (bit_start_i) begin
          if (rd_q && (cnt_q >= REL_SLOT)) begin
            oe_d   = 1'b0;
            mdio_d = 1'b0;
          end else begin
            oe_d   = 1'b1;
            mdio_d = tx_q[XFER_BITS-1];
          end
        end
        if (sample_i && rd_q) begin
          if (cnt_q == TA_SLOT) begin
            ta_bad_d = mdio_s_i;
          end
          if (cnt_q >= DATA_SLOT) begin
            rx_d = {rx_q[DATA_W-2:0], mdio_s_i};
          end
        end
        if (bit_end_i) begin
          tx_d = {tx_q[XFER_BITS-2:0], 1'b0};
          if (rd_q && (cnt_q == TA_SLOT) && ta_fail) begin
            state_d = ST_RECOV;
            cnt_d   = '0;
          end else if (cnt_q == XFER_LAST) begin
            state_d = ST_TAIL;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      ST_TAIL: begin
        if (bit_start_i) begin
          oe_d   = 1'b0;
          mdio_d = 1'b0;
        end
        if (bit_end_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b0;
          rdata_d = rd_q ? rx_q : '0;
        end
      end
      ST_RECOV: begin
        if (bit_start_i) begin
          oe_d   = 1'b0;
          mdio_d = 1'b0;
        end
        if (bit_end_i) begin
          if (cnt_q == RECOV_LAST) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            err_d   = 1'b1;
            rdata_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      rd_q     <= 1'b0;
      ta_bad_q <= 1'b0;
      mdio_q   <= 1'b0;
      oe_q     <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      rd_q     <= rd_d;
      ta_bad_q <= ta_bad_d;
      mdio_q   <= mdio_d;
      oe_q     <= oe_d;
      done_q   <= done_d;
      err_q    <= err_d;
      rdata_q  <= rdata_d;
    end
  end

  assign clk_en_o  = (state_q != ST_IDLE);
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
  assign rdata_o   = rdata_q;
  assign mdio_o    = mdio_q;
  assign mdio_oe_o = oe_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV     = 40,
  parameter int PRE_LEN     = 32,
  parameter int RECOV_LEN   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [PHY_AW-1:0] phy_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);

  // sample one synchroniser delay after the MDC rise
  localparam int SAMPLE_AT = SYNC_STAGES - 1;

  logic rst_s_n;
  logic mdio_s;
  logic clk_en;
  logic bit_start;
  logic sample;
  logic bit_end;

  mdio_sync_ff #(.STAGES(2), .RST_VAL(1'b0)) rst_sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (1'b1),
    .q_o   (rst_s_n)
  );

  mdio_sync_ff #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) in_sync_i (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d_i   (mdio_i),
    .q_o   (mdio_s)
  );

  mdio_mdc_gen #(.HALF(CLK_DIV), .SAMPLE_AT(SAMPLE_AT)) mdc_gen_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .en_i        (clk_en),
    .mdc_o       (mdc_o),
    .bit_start_o (bit_start),
    .sample_o    (sample),
    .bit_end_o   (bit_end)
  );

  mdio_ctrl #(.PRE_LEN(PRE_LEN), .RECOV_LEN(RECOV_LEN)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .start_i     (start_i),
    .rd_i        (rd_i),
    .phy_addr_i  (phy_addr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_i     (wdata_i),
    .bit_start_i (bit_start),
    .sample_i    (sample),
    .bit_end_i   (bit_end),
    .mdio_s_i    (mdio_s),
    .clk_en_o    (clk_en),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .rdata_o     (rdata_o),
    .mdio_o      (mdio_o),
    .mdio_oe_o   (mdio_oe_o)
  );

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int CLK_DIV = 40
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [15:0] rdata_o,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o
);

  localparam int HW = $clog2(CLK_DIV + 2) + 1;

  logic [HW-1:0] hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_len_q <= '0;
    end else if (mdc_o) begin
      hi_len_q <= hi_len_q + HW'(1);
    end else begin
      hi_len_q <= '0;
    end
  end

  // R4
  pad_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe_o)) |-> !mdc_o);

  // R4
  mdc_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc_o) |-> (hi_len_q == HW'(CLK_DIV)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mdc_o && !mdio_oe_o));

  // R9
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(err_o) || !$stable(rdata_o)) |-> done_o);

endmodule

bind mdio_master mdio_master_chk #(.CLK_DIV(CLK_DIV)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o),
  .rdata_o   (rdata_o),
  .mdc_o     (mdc_o),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o)
);

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

  localparam int DIV = 4;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        rd_i;
  logic [4:0]  phy_addr_i;
  logic [4:0]  reg_addr_i;
  logic [15:0] wdata_i;
  logic        busy_o;
  logic        done_o;
  logic        err_o;
  logic [15:0] rdata_o;
  logic        mdc_o;
  logic        mdio_o;
  logic        mdio_oe_o;
  logic        mdio_i;

  int n_checks;
  int n_fail;
  int n_cycles;

  // PHY model state
  logic        m_rd;
  logic        m_resp;
  logic [15:0] m_data;
  logic        phy_oe;
  logic        phy_val;
  int          rise_cnt;
  logic        cap_val [0:127];
  logic        cap_oe  [0:127];
  realtime     rise_t  [0:127];

  // monitors
  int   pad_viol;
  int   clash;
  int   done_cnt;
  logic prev_mdio;
  logic prev_oe;

  mdio_master #(.CLK_DIV(DIV)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .rd_i       (rd_i),
    .phy_addr_i (phy_addr_i),
    .reg_addr_i (reg_addr_i),
    .wdata_i    (wdata_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .rdata_o    (rdata_o),
    .mdc_o      (mdc_o),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .mdio_i     (mdio_i)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign mdio_i = phy_oe ? phy_val : (mdio_oe_o ? mdio_o : 1'b1);

  always @(posedge clk) n_cycles <= n_cycles + 1;

  always @(posedge mdc_o) begin
    automatic int k = rise_cnt;
    if (k < 128) begin
      cap_val[k] = mdio_o;
      cap_oe[k]  = mdio_oe_o;
      rise_t[k]  = $realtime;
    end
    rise_cnt = rise_cnt + 1;
    #1;
    if (m_rd && m_resp) begin
      if (k == 46) begin
        phy_oe  = 1'b1;
        phy_val = 1'b0;
      end else if (k >= 47 && k <= 62) begin
        phy_val = m_data[62-k];
      end else if (k == 63) begin
        phy_oe = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdc_o && ((mdio_o != prev_mdio) || (mdio_oe_o != prev_oe))) pad_viol++;
      if (mdio_oe_o && phy_oe) clash++;
      if (done_o) done_cnt++;
    end
    prev_mdio = mdio_o;
    prev_oe   = mdio_oe_o;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_bit(input int k, input logic rd, input logic [4:0] pa,
                                   input logic [4:0] ra, input logic [15:0] wd);
    logic [31:0] w;
    w = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra, 2'b10, wd};
    if (k < 32) return 1'b1;
    if (k < 64) return w[63-k];
    return 1'b0;
  endfunction

  function automatic int mism(input int lo, input int hi, input logic rd, input logic [4:0] pa,
                              input logic [4:0] ra, input logic [15:0] wd);
    int m = 0;
    for (int k = lo; k <= hi; k++) begin
      if (cap_oe[k] !== 1'b1 || cap_val[k] !== exp_bit(k, rd, pa, ra, wd)) m++;
    end
    return m;
  endfunction

  function automatic int oe_high(input int lo, input int hi);
    int m = 0;
    for (int k = lo; k <= hi; k++) if (cap_oe[k] !== 1'b0) m++;
    return m;
  endfunction

  task automatic run_txn(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input logic resp, input logic [15:0] pd,
                         input int inject_at);
    int waited;
    m_rd     = rd;
    m_resp   = resp;
    m_data   = pd;
    phy_oe   = 1'b0;
    phy_val  = 1'b1;
    rise_cnt = 0;
    done_cnt = 0;
    for (int k = 0; k < 128; k++) begin
      cap_val[k] = 1'bx;
      cap_oe[k]  = 1'bx;
    end
    @(negedge clk);
    rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    waited = 0;
    while (!done_o && waited < 5000) begin
      @(negedge clk);
      waited++;
      if (waited == inject_at) begin
        rd_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        waited++;
      end
    end
    check(waited < 5000, "R9 access never ended", waited, 5000);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    check(!mdc_o && !mdio_oe_o, "R10 pad quiet in reset", {mdc_o, mdio_oe_o}, 0);
    check(!busy_o && !done_o && !err_o && rdata_o == 16'h0, "R10 outputs zero in reset",
          {busy_o, done_o, err_o, rdata_o}, 0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    run_txn(1'b0, pa, ra, wd, 1'b1, 16'h0, 0);
    check(mism(0, 31, 1'b0, pa, ra, wd) == 0, "R1 write preamble", mism(0, 31, 1'b0, pa, ra, wd), 0);
    check(mism(32, 35, 1'b0, pa, ra, wd) == 0, "R2 write start/opcode 0101",
          {cap_val[32], cap_val[33], cap_val[34], cap_val[35]}, 4'b0101);
    check(mism(36, 45, 1'b0, pa, ra, wd) == 0, "R3 write addresses", mism(36, 45, 1'b0, pa, ra, wd), 0);
    check(mism(46, 63, 1'b0, pa, ra, wd) == 0, "R5 write turnaround and data",
          mism(46, 63, 1'b0, pa, ra, wd), 0);
    check(cap_oe[64] === 1'b0 && rise_cnt == 65, "R5 write release and length", rise_cnt, 65);
    check(!err_o && rdata_o == 16'h0, "R11 write result", {err_o, rdata_o}, 0);
    check(done_cnt == 1 && !busy_o, "R9 single done pulse", done_cnt, 1);
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pd);
    run_txn(1'b1, pa, ra, 16'h0, 1'b1, pd, 0);
    check(mism(0, 31, 1'b1, pa, ra, 16'h0) == 0, "R1 read preamble", mism(0, 31, 1'b1, pa, ra, 16'h0), 0);
    check(mism(32, 35, 1'b1, pa, ra, 16'h0) == 0, "R2 read start/opcode 0110",
          {cap_val[32], cap_val[33], cap_val[34], cap_val[35]}, 4'b0110);
    check(mism(36, 45, 1'b1, pa, ra, 16'h0) == 0, "R3 read addresses", mism(36, 45, 1'b1, pa, ra, 16'h0), 0);
    check(oe_high(46, 64) == 0, "R6 read line released", oe_high(46, 64), 0);
    check(rdata_o == pd && !err_o, "R7 read data", rdata_o, pd);
    check(rise_cnt == 65, "R7 read length", rise_cnt, 65);
  endtask

  task automatic t_abort(input logic [4:0] pa, input logic [4:0] ra);
    run_txn(1'b1, pa, ra, 16'h0, 1'b0, 16'h0, 0);
    check(rise_cnt == 80, "R8 abort length", rise_cnt, 80);
    check(oe_high(46, 79) == 0, "R8 released during recovery", oe_high(46, 79), 0);
    check(err_o && rdata_o == 16'h0, "R8 abort result", {err_o, rdata_o}, 17'h10000);
    repeat (20) @(negedge clk);
    check(err_o && !busy_o, "R11 error held", {err_o, busy_o}, 2'b10);
  endtask

  task automatic t_ignore(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd);
    run_txn(1'b0, pa, ra, wd, 1'b1, 16'h0, 150);
    check(mism(0, 63, 1'b0, pa, ra, wd) == 0 && rise_cnt == 65, "R9 start while busy ignored",
          rise_cnt, 65);
    repeat (30) @(negedge clk);
    check(!busy_o && done_cnt == 1, "R9 no second access", {busy_o, done_cnt}, 1);
  endtask

  task automatic t_timing;
    check((rise_t[2] - rise_t[1]) == 2.0 * DIV * 5.0, "R4 MDC period",
          int'(rise_t[2] - rise_t[1]), 2 * DIV * 5);
    check(pad_viol == 0, "R4 pad changed while MDC high", pad_viol, 0);
    check(clash == 0, "R6 PHY and master drove together", clash, 0);
  endtask

  initial begin
    n_checks = 0; n_fail = 0; n_cycles = 0;
    pad_viol = 0; clash = 0; done_cnt = 0; rise_cnt = 0;
    m_rd = 1'b0; m_resp = 1'b0; m_data = 16'h0;
    phy_oe = 1'b0; phy_val = 1'b1;
    start_i = 1'b0; rd_i = 1'b0; phy_addr_i = '0; reg_addr_i = '0; wdata_i = '0;
    rst_n = 1'b0;
    repeat (6) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_write(5'h11, 5'h04, 16'hA5C3);
    t_timing();
    t_read(5'h03, 5'h1E, 16'h9C3A);
    t_read(5'h1F, 5'h01, 16'h8001);
    t_abort(5'h07, 5'h02);
    t_write(5'h00, 5'h1F, 16'h0F0F);
    t_ignore(5'h0A, 5'h15, 16'h7E81);
    t_timing();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x%0h expected=0x0", n_cycles);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule